// File: doc/BRIEF.md
# Fail-Open Packet Tap with Monitor Records

This block sits in series on a beat-based packet stream. Every beat taken on the live ingress leaves on the live egress, unchanged, after a fixed number of clock cycles. The live path is a plain register chain that has no ready input, so nothing downstream or on the monitor side can slow it, reorder it or stop it.

For every packet that ends while the block is healthy, the block builds one compact record and queues it for a separate monitor port. The record holds the first header beats verbatim, the value of a free-running cycle counter taken when the first beat arrived, and a CRC-32 digest over the remaining beats. The payload bytes themselves never reach the monitor port. The monitor port has a valid/ready handshake. If it stalls long enough that a finished record cannot be queued, the block raises a sticky fail flag and stops making records, and live forwarding goes on exactly as before.

Top module: `pkt_tap`

## Requirements
- R1: A beat sampled on live ingress with `in_valid` high appears on `out_valid`/`out_last`/`out_data` exactly LAT clock cycles later, with its data and last flag bit-exact. Every beat is forwarded, whatever its length or spacing, including back-to-back packets.
- R2: `out_valid` is high in a cycle only if `in_valid` was sampled high LAT cycles earlier. Idle ingress cycles give idle egress cycles.
- R3: Each packet whose last beat is sampled while `fail_o` is low and the record queue has room (or is being popped in that cycle) produces exactly one record. With an empty queue, the record is offered on `mon_valid` in the cycle after the last beat. `mon_valid` is high exactly while queued records remain.
- R4: `mon_hdr` holds packet beat 0 in bits [DW-1:0] and beat 1 in bits [2*DW-1:DW]. A header beat that the packet does not have reads as zero.
- R5: `mon_ts` is the value of a TS_W-bit counter sampled in the cycle of the packet's first beat. The counter reads 0 in the first cycle after reset is released and increments by one every cycle.
- R6: `mon_digest` is the CRC-32 of all beats after the header beats, bytes taken lowest byte first and bits lowest first: reflected polynomial 0xEDB88320, register preset to all ones, final result inverted. A packet of one or two beats has digest 0.
- R7: Records leave in packet order, each exactly once. While `mon_valid` is high and `mon_ready` is low, the record on the monitor port stays unchanged.
- R8: If a last beat is sampled while FIFO_DEPTH records are queued and none is popped in that cycle, `fail_o` rises in the next cycle and stays high until reset. No record is made for that packet or any later one, and records already queued are still delivered.
- R9: Live egress is cycle-for-cycle identical for the same ingress stimulus, whatever `mon_ready` does and whether or not `fail_o` is set.
- R10: While reset is held, `out_valid`, `mon_valid` and `fail_o` are low; reset clears a previously set `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Live ingress beat valid |
| in_data | input | DW | Live ingress beat data |
| in_last | input | 1 | Live ingress last beat of packet |
| out_valid | output | 1 | Live egress beat valid |
| out_data | output | DW | Live egress beat data |
| out_last | output | 1 | Live egress last beat of packet |
| mon_valid | output | 1 | Monitor record available |
| mon_ready | input | 1 | Monitor consumer accepts record |
| mon_hdr | output | HDR_BEATS*DW | Header beats of the packet |
| mon_ts | output | TS_W | Arrival timestamp of first beat |
| mon_digest | output | 32 | CRC-32 digest of beats after the header |
| fail_o | output | 1 | Sticky fault flag |

## Verification
The bench builds the tap with DW=64, LAT=3, HDR_BEATS=2, TS_W=48 and FIFO_DEPTH=4. The three-stage live chain keeps several beats and packet boundaries in flight at once, so back-to-back packets and packets of one, two and three beats overlap inside it. The four-entry queue overflows within a few packets once the monitor port accepts only about a third of the time, which brings the fail path, the drain of the records held before the fault and the identical egress traces of a stalled run and a free run into a short test.

// File: rtl/tap_pkg.sv
package tap_pkg;
   localparam int          DIG_W    = 32;
   localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
   localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/tap_live_pipe.sv
module tap_live_pipe #(
   parameter int DW  = 64,
   parameter int LAT = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic          in_last,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic          out_last,
   output logic [DW-1:0] out_data
);
   generate
      if (LAT < 1) begin : g_bad_lat
         $error("tap_live_pipe: LAT must be at least 1");
      end
   endgenerate

   logic [LAT-1:0] vld_q;
   logic [LAT-1:0] lst_q;
   logic [DW-1:0]  dat_q [LAT];

   generate
      if (LAT == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) begin
               vld_q <= '0;
               lst_q <= '0;
            end else begin
               vld_q[0] <= in_valid;
               lst_q[0] <= in_last;
            end
            dat_q[0] <= in_data;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) begin
               vld_q <= '0;
               lst_q <= '0;
            end else begin
               vld_q <= {vld_q[LAT-2:0], in_valid};
               lst_q <= {lst_q[LAT-2:0], in_last};
            end
            dat_q[0] <= in_data;
            for (int i = 1; i < LAT; i++) dat_q[i] <= dat_q[i-1];
         end
      end
   endgenerate

   assign out_valid = vld_q[LAT-1];
   assign out_last  = lst_q[LAT-1];
   assign out_data  = dat_q[LAT-1];

   // beats taken minus beats emitted, kept only for the checks below
   int infl_q;
   always_ff @(posedge clk) begin
      if (rst) infl_q <= 0;
      else     infl_q <= infl_q + int'(in_valid) - int'(out_valid);
   end

   assert_inflight_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (infl_q > 0));
   assert_bound_R1: assert property (@(posedge clk) disable iff (rst)
      infl_q <= LAT);
endmodule

// File: rtl/tap_rec_builder.sv
module tap_rec_builder
   import tap_pkg::*;
#(
   parameter int DW        = 64,
   parameter int HDR_BEATS = 2,
   parameter int TS_W      = 48
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [DW-1:0]           in_data,
   input  logic                    in_last,
   input  logic                    enable,
   output logic                    rec_push,
   output logic [HDR_BEATS*DW-1:0] rec_hdr,
   output logic [TS_W-1:0]         rec_ts,
   output logic [DIG_W-1:0]        rec_dig
);
   localparam int IW = $clog2(HDR_BEATS + 1);
   localparam logic [IW-1:0] IDX_PAY = IW'(HDR_BEATS);

   generate
      if (HDR_BEATS < 1) begin : g_bad_hdr
         $error("tap_rec_builder: HDR_BEATS must be at least 1");
      end
      if (DW % 8 != 0) begin : g_bad_dw
         $error("tap_rec_builder: DW must be a whole number of bytes");
      end
   endgenerate

   function automatic logic [DIG_W-1:0] crc_beat(input logic [DIG_W-1:0] c_in,
                                                 input logic [DW-1:0]    d);
      logic [DIG_W-1:0] c;
      logic             fb;
      c = c_in;
      for (int i = 0; i < DW; i++) begin
         fb = c[0] ^ d[i];
         c  = {1'b0, c[DIG_W-1:1]} ^ (fb ? CRC_POLY : '0);
      end
      return c;
   endfunction

   logic [IW-1:0]    idx_q;
   logic [TS_W-1:0]  tick_q;
   logic [TS_W-1:0]  ts_q;
   logic [DIG_W-1:0] crc_q;
   logic [DW-1:0]    hdr_q [HDR_BEATS];

   logic             first_beat;
   logic             pay_beat;
   logic [DIG_W-1:0] crc_base;

   assign first_beat = in_valid && (idx_q == '0);
   assign pay_beat   = in_valid && (idx_q == IDX_PAY);
   assign crc_base   = first_beat ? CRC_INIT : crc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_q <= '0;
         idx_q  <= '0;
      end else begin
         tick_q <= tick_q + 1'b1;
         if (in_valid) begin
            if (in_last)               idx_q <= '0;
            else if (idx_q != IDX_PAY) idx_q <= idx_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (first_beat) ts_q <= tick_q;
      if (first_beat)    crc_q <= CRC_INIT;
      else if (pay_beat) crc_q <= crc_beat(crc_q, in_data);
   end

   generate
      for (genvar g = 0; g < HDR_BEATS; g++) begin : g_hdr
         logic hit;
         assign hit = in_valid && (idx_q == IW'(g));
         always_ff @(posedge clk) begin
            if (hit) hdr_q[g] <= in_data;
         end
         assign rec_hdr[g*DW +: DW] = hit              ? in_data  :
                                      (idx_q > IW'(g)) ? hdr_q[g] : '0;
      end
   endgenerate

   assign rec_ts   = first_beat ? tick_q : ts_q;
   assign rec_dig  = ~(pay_beat ? crc_beat(crc_base, in_data) : crc_base);
   assign rec_push = in_valid && in_last && enable;

   assert_ts_past_R5: assert property (@(posedge clk) disable iff (rst)
      rec_push |-> (rec_ts <= tick_q));
   assert_short_digest_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_last && (idx_q < IDX_PAY)) |-> (rec_dig == '0));
endmodule

// File: rtl/tap_rec_fifo.sv
module tap_rec_fifo #(
   parameter int W     = 208,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("tap_rec_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [AW:0]   cnt_q;
   logic          full, pop, wr_en;

   assign full      = (cnt_q == (AW+1)'(DEPTH));
   assign out_valid = (cnt_q != '0);
   assign out_data  = mem[rd_q];
   assign pop       = out_valid && pop_ready;
   assign ovf       = push && full && !pop;
   assign wr_en     = push && (!full || pop);

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en) wr_q <= wr_q + 1'b1;
         if (pop)   rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + (AW+1)'(wr_en) - (AW+1)'(pop);
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= (AW+1)'(DEPTH));
   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pkt_tap.sv
module pkt_tap
   import tap_pkg::*;
#(
   parameter int DW         = 64,
   parameter int LAT        = 3,
   parameter int HDR_BEATS  = 2,
   parameter int TS_W       = 48,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [DW-1:0]           in_data,
   input  logic                    in_last,
   output logic                    out_valid,
   output logic [DW-1:0]           out_data,
   output logic                    out_last,
   output logic                    mon_valid,
   input  logic                    mon_ready,
   output logic [HDR_BEATS*DW-1:0] mon_hdr,
   output logic [TS_W-1:0]         mon_ts,
   output logic [DIG_W-1:0]        mon_digest,
   output logic                    fail_o
);
   localparam int HW = HDR_BEATS * DW;
   localparam int RW = HW + TS_W + DIG_W;

   generate
      if (TS_W < 8 || TS_W > 64) begin : g_bad_ts
         $error("pkt_tap: TS_W must lie between 8 and 64");
      end
   endgenerate

   // live path: no monitor-side signal reaches it
   tap_live_pipe #(.DW(DW), .LAT(LAT)) u_live (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_last  (out_last),
      .out_data  (out_data)
   );

   logic          fail_q;
   logic          rec_push;
   logic [HW-1:0] rec_hdr;
   logic [TS_W-1:0]  rec_ts;
   logic [DIG_W-1:0] rec_dig;
   logic [RW-1:0] fifo_out;
   logic          ovf;

   tap_rec_builder #(.DW(DW), .HDR_BEATS(HDR_BEATS), .TS_W(TS_W)) u_build (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .enable   (!fail_q),
      .rec_push (rec_push),
      .rec_hdr  (rec_hdr),
      .rec_ts   (rec_ts),
      .rec_dig  (rec_dig)
   );

   tap_rec_fifo #(.W(RW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (rec_push),
      .push_data ({rec_hdr, rec_ts, rec_dig}),
      .pop_ready (mon_ready),
      .out_valid (mon_valid),
      .out_data  (fifo_out),
      .ovf       (ovf)
   );

   always_ff @(posedge clk) begin
      if (rst)      fail_q <= 1'b0;
      else if (ovf) fail_q <= 1'b1;
   end

   assign mon_hdr    = fifo_out[RW-1 -: HW];
   assign mon_ts     = fifo_out[DIG_W +: TS_W];
   assign mon_digest = fifo_out[DIG_W-1:0];
   assign fail_o     = fail_q;

   assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      fail_q |=> fail_q);
   assert_no_new_rec_R8: assert property (@(posedge clk) disable iff (rst)
      (fail_q && !mon_valid) |=> !mon_valid);
   assert_reset_idle_R10: assert property (@(posedge clk)
      rst |=> (!out_valid && !mon_valid && !fail_o));
endmodule

// File: tb/pkt_tap_bench.sv
module pkt_tap_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW    = 64;
   localparam int LAT   = 3;
   localparam int HB    = 2;
   localparam int TS_W  = 48;
   localparam int DEPTH = 4;
   localparam int RW    = HB*DW + TS_W + 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0, in_last = 1'b0, mon_ready = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic out_valid, out_last, mon_valid, fail_o;
   logic [DW-1:0] out_data;
   logic [HB*DW-1:0] mon_hdr;
   logic [TS_W-1:0] mon_ts;
   logic [31:0] mon_digest;

   pkt_tap #(.DW(DW), .LAT(LAT), .HDR_BEATS(HB), .TS_W(TS_W), .FIFO_DEPTH(DEPTH)) u_pkt_tap (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .mon_valid(mon_valid), .mon_ready(mon_ready), .mon_hdr(mon_hdr),
      .mon_ts(mon_ts), .mon_digest(mon_digest), .fail_o(fail_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int bad = 0;

   // spec-level cycle counter (R5): 0 on first cycle after release, +1 per cycle
   logic [TS_W-1:0] tsm = '0;
   always @(posedge clk) tsm <= rst ? '0 : tsm + 1'b1;

   logic [DW+1:0] hist [64];
   logic [DW+1:0] elog [2][1024];
   int  nlog [2];
   int  n, run, ready_pct;
   bit  logging;
   logic [RW-1:0] expq [$];
   int  cnt_m;
   bit  fail_m;
   int  bi;
   logic [DW-1:0] h0, h1;
   logic [TS_W-1:0] tsc;
   logic [31:0] crc_m;
   logic [RW-1:0] prev_rec;
   bit  prev_hold;
   logic [63:0] rng;

   function automatic logic [63:0] rnd64(inout logic [63:0] s);
      s = s ^ (s << 13);
      s = s ^ (s >> 7);
      s = s ^ (s << 17);
      return s;
   endfunction

   function automatic logic [31:0] crc_ref(input logic [31:0] c_in, input logic [63:0] d);
      logic [31:0] c;
      c = c_in;
      for (int b = 0; b < 8; b++) begin
         c = c ^ {24'h0, d[8*b +: 8]};
         for (int k = 0; k < 8; k++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input bit l, input logic [DW-1:0] d);
      logic [DW+1:0] e;
      bit r, pop_m;
      @(negedge clk);
      e = (n >= LAT) ? hist[(n - LAT) % 64] : '0;
      if (e[DW+1]) check({out_valid, out_last, out_data} === e, "R1", "egress beat",
                         {out_valid, out_last, out_data}, e);
      else         check(out_valid === 1'b0, "R2", "egress idle", out_valid, 0);
      if (logging && n < 1024) elog[run][n] = {out_valid, out_last, out_valid ? out_data : '0};
      check(fail_o === fail_m, "R8", "fail flag", fail_o, fail_m);
      check(mon_valid === (cnt_m > 0), "R3", "mon_valid", mon_valid, cnt_m > 0);
      if (prev_hold)
         check({mon_hdr, mon_ts, mon_digest} === prev_rec, "R7", "held record",
               {mon_hdr, mon_ts, mon_digest}, prev_rec);
      r = ($urandom % 100) < ready_pct;
      pop_m = 1'b0;
      if (cnt_m > 0 && r) begin
         check(mon_hdr === expq[0][RW-1 -: HB*DW], "R4", "header", mon_hdr, expq[0][RW-1 -: HB*DW]);
         check(mon_ts === expq[0][32 +: TS_W], "R5", "timestamp", mon_ts, expq[0][32 +: TS_W]);
         check(mon_digest === expq[0][31:0], "R6", "digest", mon_digest, expq[0][31:0]);
         void'(expq.pop_front());
         pop_m = 1'b1;
      end
      prev_hold = mon_valid && !r;
      prev_rec  = {mon_hdr, mon_ts, mon_digest};
      in_valid = v; in_last = l; in_data = d; mon_ready = r;
      hist[n % 64] = {v, l, d};
      n++;
      if (v) begin
         if (bi == 0) begin h0 = d; h1 = '0; tsc = tsm; crc_m = 32'hFFFFFFFF; end
         else if (bi == 1) h1 = d;
         else crc_m = crc_ref(crc_m, d);
         if (l) begin
            bi = 0;
            if (!fail_m) begin
               if (cnt_m == DEPTH && !pop_m) fail_m = 1'b1;
               else begin expq.push_back({h1, h0, tsc, ~crc_m}); cnt_m++; end
            end
         end else if (bi < 2) bi++;
      end
      if (pop_m) cnt_m--;
   endtask

   task automatic do_reset();
      rst = 1'b1; in_valid = 0; in_last = 0; in_data = '0; mon_ready = 0;
      repeat (3) begin
         @(negedge clk);
         check(!out_valid && !mon_valid && !fail_o, "R10", "idle in reset",
               {out_valid, mon_valid, fail_o}, 0);
      end
      for (int i = 0; i < 64; i++) hist[i] = '0;
      n = 0; expq.delete(); cnt_m = 0; fail_m = 0; bi = 0; prev_hold = 0;
      rst = 1'b0;
   endtask

   task automatic send_pkt(input int len, input int gap);
      for (int b = 0; b < len; b++) step(1'b1, b == len - 1, rnd64(rng));
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, rnd64(rng));
   endtask

   task automatic stream(input int which, input int pct);
      run = which; ready_pct = pct; logging = 1; rng = 64'h0123_4567_89AB_CDEF;
      do_reset();
      for (int k = 0; k < 40; k++) begin
         if (k < 3) send_pkt(k + 1, 0);
         else send_pkt(1 + int'(rnd64(rng) % 8), int'(rnd64(rng) % 3));
      end
      for (int i = 0; i < 20; i++) step(1'b0, 1'b0, '0);
      nlog[which] = n;
      logging = 0;
   endtask

   bit done = 0;
   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(42));
      // free-running monitor: every record taken at once (R3..R6)
      stream(0, 100);
      // stalled monitor, same live stimulus (R7, R8)
      stream(1, 30);
      // R9: egress traces must match cycle for cycle
      check(nlog[0] == nlog[1], "R9", "trace length", nlog[1], nlog[0]);
      for (int i = 0; i < nlog[0] && i < 1024; i++)
         check(elog[0][i] === elog[1][i], "R9", "egress vs stalled run", elog[1][i], elog[0][i]);
      // directed overflow (R8), then reset clears fail (R10)
      ready_pct = 0; rng = 64'hDEAD_BEEF_0000_1111;
      do_reset();
      for (int k = 0; k < DEPTH; k++) send_pkt(3, 1);
      check(fail_o === 1'b0, "R8", "full queue no fail yet", fail_o, 0);
      send_pkt(2, 2);
      check(fail_o === 1'b1, "R8", "fail after overflow", fail_o, 1);
      ready_pct = 100;
      for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0);
      check(expq.size() == 0 && mon_valid === 1'b0, "R8", "queued records drained",
            mon_valid, 0);
      send_pkt(4, 0);
      send_pkt(1, 4);
      check(mon_valid === 1'b0, "R8", "no record after fail", mon_valid, 0);
      do_reset();
      step(1'b0, 1'b0, '0);
      check(fail_o === 1'b0, "R10", "fail cleared by reset", fail_o, 0);
      send_pkt(5, 0);
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0);
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule